// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the pin-level timing of a multiplexed external memory bus for an 8-bit controller core. One 8-bit port carries the low address byte and then the data. A second port carries the high address byte. An active-high address-latch strobe lets an external latch capture the low address. An active-low program strobe opens external code memory onto the shared port. Active-low read and write strobes serve external data memory.

Time is divided into bus slots of six oscillator clocks. A free-running phase counter marks the slots, and the latch strobe pulses once per slot. The core raises a code request or a data read or write request together with a 16-bit address. The block takes that request in the last clock of a slot, which it signals on `req_take`, and runs the access in the following slot or pair of slots.

A code fetch is internal, and leaves the bus quiet, when the external-access input is high and the address falls inside the on-chip code size. Otherwise the fetch is external. A data access always uses two slots, and the latch pulse of the second slot is left out. Bytes read from the bus are returned on `rd_data` with a one-clock `rd_valid` pulse.

Top module: `xbus_seq`

## Requirements
- R1: While `rst` is high, `ale_oe` and `psen_oe` are 0, so both strobe pads float onto their weak pull-ups. In the same state `rd_n` and `wr_n` are 1 and `p0_oe` and `p2_oe` are 0. Asserting reset in the middle of an access applies all of this at once, without waiting for a clock edge.
- R2: After reset, slots of 6 clocks follow each other without a gap, starting at phase 0 on the first clock after reset. `ale_o` is 1 in phases 0 and 1 of every slot that is not the second slot of a data access, and 0 in all other phases.
- R3: A data access takes two consecutive slots, 12 clocks in all. `ale_o` pulses in the first of these slots only, so exactly one pulse is skipped.
- R4: For every external access, `p2_oe` is 1 and `p2_do` equals address bits 15:8 for the whole access. `p0_oe` is 1 and `p0_do` equals address bits 7:0 in phases 0 to 2 of the first slot. The port therefore holds the address through the falling edge of `ale_o` and for one clock after it.
- R5: In an external code fetch, `psen_n_o` is 0 in phases 3 to 5 and `p0_oe` is 0 in those phases. The value on `p0_di` in phase 5 appears on `rd_data`, with `rd_valid` at 1, in the next clock.
- R6: When `ea_n` is 1, a code fetch from an address below `INT_CODE_BYTES` (16384 by default) is internal. During that slot `psen_n_o`, `rd_n` and `wr_n` stay 1, `p0_oe` and `p2_oe` stay 0, and no `rd_valid` pulse follows. From address `INT_CODE_BYTES` upward the fetch is external.
- R7: When `ea_n` is 0, every code fetch is external, at any address.
- R8: In an external data read, `psen_n_o` stays 1 for both slots. `rd_n` is 0 from phase 4 of the first slot to the end of the second slot. `p0_oe` is 0 from phase 3 of the first slot onward. The value on `p0_di` in the last clock appears on `rd_data`, with `rd_valid` at 1, in the next clock.
- R9: In an external data write, `psen_n_o` and `rd_n` stay 1. `wr_n` is 0 from phase 4 of the first slot to the end of the second slot. `p0_oe` is 1 and `p0_do` equals the write data from phase 3 of the first slot to the end of the second, which covers the whole write strobe.
- R10: Requests are sampled only in phase 5, with `req_take` at 1 in that clock. No request is sampled at the end of the first slot of a data access. A data request wins over a simultaneous code request, and a read wins over a simultaneous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Asynchronous reset, active high |
| ea_n | input | 1 | External-access select, low forces external code fetches |
| req_code | input | 1 | Code fetch or table-read request |
| req_xrd | input | 1 | External data read request |
| req_xwr | input | 1 | External data write request |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_take | output | 1 | Request accepted in this clock |
| rd_data | output | 8 | Byte read from the bus |
| rd_valid | output | 1 | One-clock pulse marking `rd_data` as new |
| p0_di | input | 8 | Shared port, value seen at the pads |
| p0_do | output | 8 | Shared port drive value |
| p0_oe | output | 1 | Shared port drive enable |
| p2_do | output | 8 | High address port drive value |
| p2_oe | output | 1 | High address port drive enable |
| ale_o | output | 1 | Address-latch strobe, active high |
| ale_oe | output | 1 | Address-latch strobe pad enable |
| psen_n_o | output | 1 | Program strobe, active low |
| psen_oe | output | 1 | Program strobe pad enable |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
The bench targets the on-chip code limit at 0x3FFF and 0x4000, under both settings of `ea_n`. A block that gets the comparison wrong by one would pulse the program strobe for a fetch that should stay internal, or skip an external fetch. It also checks the latch pulse in the second slot of every data access, which a wrong block would emit or move, and the one clock of address hold after the strobe falls, where a wrong block would turn the port around too early. Finally it checks priority and sampling when requests stay asserted across a data access, where a wrong block would take a new request halfway through the access. It also checks reset asserted in the middle of a write, which must release the port and the write strobe at once.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      SL_IDLE     = 3'd0,
      SL_CODE_EXT = 3'd1,
      SL_CODE_INT = 3'd2,
      SL_DATA_A   = 3'd3,
      SL_DATA_B   = 3'd4
   } slot_e;
endpackage

// File: rtl/xbus_phase_ctr.sv
module xbus_phase_ctr #(
   parameter int SLOT_CLKS = 6,
   parameter int PH_W      = $clog2(SLOT_CLKS)
) (
   input  logic            clk,
   input  logic            rst,
   output logic [PH_W-1:0] phase,
   output logic            slot_end
);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(SLOT_CLKS - 1);

   assign slot_end = (phase == LAST_PH);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)           phase <= '0;
      else if (slot_end) phase <= '0;
      else               phase <= phase + 1'b1;
   end
endmodule

// File: rtl/xbus_slot_ctrl.sv
module xbus_slot_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 8,
   parameter int INT_CODE_BYTES = 16384
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slot_end,
   input  logic              ea_n,
   input  logic              req_code,
   input  logic              req_xrd,
   input  logic              req_xwr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_take,
   output slot_e             kind,
   output logic              is_wr,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q
);
   logic code_ext;
   logic any_req;

   generate
      if (INT_CODE_BYTES == 0) begin : g_no_rom
         assign code_ext = 1'b1;
      end else begin : g_rom
         localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W+1)'(INT_CODE_BYTES);
         assign code_ext = !ea_n || ({1'b0, req_addr} >= ROM_LIM);
      end
   endgenerate

   assign any_req  = req_code | req_xrd | req_xwr;
   assign req_take = slot_end && (kind != SL_DATA_A) && any_req;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         kind    <= SL_IDLE;
         is_wr   <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (slot_end) begin
         if (kind == SL_DATA_A) begin
            kind <= SL_DATA_B;
         end else if (req_xrd || req_xwr) begin
            kind    <= SL_DATA_A;
            is_wr   <= !req_xrd;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end else if (req_code) begin
            kind   <= code_ext ? SL_CODE_EXT : SL_CODE_INT;
            is_wr  <= 1'b0;
            addr_q <= req_addr;
         end else begin
            kind <= SL_IDLE;
         end
      end
   end
endmodule

// File: rtl/xbus_pad_decode.sv
module xbus_pad_decode
   import xbus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SLOT_CLKS = 6,
   parameter int ALE_CLKS  = 2,
   parameter int ADDR_HOLD = 1,
   parameter int PH_W      = $clog2(SLOT_CLKS)
) (
   input  logic              rst,
   input  logic [PH_W-1:0]   phase,
   input  slot_e             kind,
   input  logic              is_wr,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] p0_do,
   output logic              p0_oe,
   output logic [DATA_W-1:0] p2_do,
   output logic              p2_oe,
   output logic              ale_o,
   output logic              ale_oe,
   output logic              psen_n_o,
   output logic              psen_oe,
   output logic              rd_n,
   output logic              wr_n
);
   localparam logic [PH_W-1:0] ALE_END = PH_W'(ALE_CLKS);
   localparam logic [PH_W-1:0] DATA_PH = PH_W'(ALE_CLKS + ADDR_HOLD);
   localparam logic [PH_W-1:0] STRB_PH = PH_W'(ALE_CLKS + ADDR_HOLD + 1);

   logic ext_addr, addr_win, data_win, strb_win, on_bus;

   assign on_bus   = (kind == SL_CODE_EXT) || (kind == SL_DATA_A) || (kind == SL_DATA_B);
   assign ext_addr = (kind == SL_CODE_EXT) || (kind == SL_DATA_A);
   assign addr_win = ext_addr && (phase < DATA_PH);
   assign data_win = ((kind == SL_DATA_A) && (phase >= DATA_PH)) || (kind == SL_DATA_B);
   assign strb_win = ((kind == SL_DATA_A) && (phase >= STRB_PH)) || (kind == SL_DATA_B);

   always_comb begin
      ale_oe   = !rst;
      psen_oe  = !rst;
      ale_o    = (phase < ALE_END) && (kind != SL_DATA_B);
      psen_n_o = !((kind == SL_CODE_EXT) && (phase >= DATA_PH));
      rd_n     = !(strb_win && !is_wr);
      wr_n     = !(strb_win && is_wr);
      p2_oe    = on_bus;
      p2_do    = addr_q[ADDR_W-1 -: DATA_W];
      p0_oe    = addr_win || (data_win && is_wr);
      p0_do    = addr_win ? addr_q[DATA_W-1:0] : wdata_q;
   end
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
   import xbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slot_end,
   input  slot_e             kind,
   input  logic              is_wr,
   input  logic [DATA_W-1:0] p0_di,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic cap;

   assign cap = slot_end && ((kind == SL_CODE_EXT) || ((kind == SL_DATA_B) && !is_wr));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= cap;
         if (cap) rd_data <= p0_di;
      end
   end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 8,
   parameter int SLOT_CLKS      = 6,
   parameter int ALE_CLKS       = 2,
   parameter int ADDR_HOLD      = 1,
   parameter int INT_CODE_BYTES = 16384
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ea_n,
   input  logic              req_code,
   input  logic              req_xrd,
   input  logic              req_xwr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_take,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic [DATA_W-1:0] p0_di,
   output logic [DATA_W-1:0] p0_do,
   output logic              p0_oe,
   output logic [DATA_W-1:0] p2_do,
   output logic              p2_oe,
   output logic              ale_o,
   output logic              ale_oe,
   output logic              psen_n_o,
   output logic              psen_oe,
   output logic              rd_n,
   output logic              wr_n
);
   localparam int PH_W = $clog2(SLOT_CLKS);

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("xbus_seq: ADDR_W must be twice DATA_W");
      end
      if (SLOT_CLKS < ALE_CLKS + ADDR_HOLD + 2) begin : g_bad_slot
         $error("xbus_seq: slot too short for strobe, hold and access");
      end
      if (ALE_CLKS < 1 || ADDR_HOLD < 1) begin : g_bad_ale
         $error("xbus_seq: ALE_CLKS and ADDR_HOLD must be at least 1");
      end
      if (INT_CODE_BYTES < 0 || INT_CODE_BYTES > (1 << ADDR_W)) begin : g_bad_rom
         $error("xbus_seq: INT_CODE_BYTES outside the address space");
      end
   endgenerate

   logic [PH_W-1:0]   phase;
   logic              slot_end;
   slot_e             kind;
   logic              is_wr;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   xbus_phase_ctr #(.SLOT_CLKS(SLOT_CLKS), .PH_W(PH_W)) u_phase (
      .clk(clk), .rst(rst), .phase(phase), .slot_end(slot_end)
   );

   xbus_slot_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_CODE_BYTES(INT_CODE_BYTES)
   ) u_ctrl (
      .clk(clk), .rst(rst), .slot_end(slot_end), .ea_n(ea_n),
      .req_code(req_code), .req_xrd(req_xrd), .req_xwr(req_xwr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_take(req_take),
      .kind(kind), .is_wr(is_wr), .addr_q(addr_q), .wdata_q(wdata_q)
   );

   xbus_pad_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_CLKS(SLOT_CLKS),
      .ALE_CLKS(ALE_CLKS), .ADDR_HOLD(ADDR_HOLD), .PH_W(PH_W)
   ) u_pads (
      .rst(rst), .phase(phase), .kind(kind), .is_wr(is_wr),
      .addr_q(addr_q), .wdata_q(wdata_q),
      .p0_do(p0_do), .p0_oe(p0_oe), .p2_do(p2_do), .p2_oe(p2_oe),
      .ale_o(ale_o), .ale_oe(ale_oe), .psen_n_o(psen_n_o), .psen_oe(psen_oe),
      .rd_n(rd_n), .wr_n(wr_n)
   );

   xbus_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst(rst), .slot_end(slot_end), .kind(kind), .is_wr(is_wr),
      .p0_di(p0_di), .rd_data(rd_data), .rd_valid(rd_valid)
   );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
   parameter int DATA_W    = 8,
   parameter int SLOT_CLKS = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              ale_o,
   input logic              ale_oe,
   input logic              psen_n_o,
   input logic              psen_oe,
   input logic              rd_n,
   input logic              wr_n,
   input logic              p0_oe,
   input logic [DATA_W-1:0] p0_do,
   input logic              p2_oe,
   input logic              rd_valid
);
   localparam int CW = $clog2(2 * SLOT_CLKS + 2) + 1;
   localparam logic [CW-1:0] ONE_SLOT = CW'(SLOT_CLKS);
   localparam logic [CW-1:0] TWO_SLOT = CW'(2 * SLOT_CLKS);
   localparam logic [CW-1:0] CMAX     = {CW{1'b1}};

   logic          ale_q;
   logic [CW-1:0] gap;
   logic          ale_rise;

   assign ale_rise = ale_o && !ale_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ale_q <= 1'b1;
         gap   <= '0;
      end else begin
         ale_q <= ale_o;
         if (ale_rise)         gap <= 1;
         else if (gap != CMAX) gap <= gap + 1'b1;
      end
   end

   // R2 / R3: pulses are one or two slots apart
   always @(posedge clk) begin
      if (!rst && ale_rise)
         a_r3_ale_spacing: assert (gap == ONE_SLOT || gap == TWO_SLOT)
            else $error("ALE pulse spacing %0d", gap);
   end

   // R1
   always @(posedge clk) begin
      if (rst)
         a_r1_reset_hiz: assert (!ale_oe && !psen_oe && rd_n && wr_n && !p0_oe && !p2_oe)
            else $error("pads driven during reset");
   end

   a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (rst)
      ale_o |-> (psen_n_o && rd_n && wr_n));

   a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
      $fell(ale_o) |-> (p0_oe == $past(p0_oe)) && (!p0_oe || p0_do == $past(p0_do)));

   a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
      (!psen_n_o || !rd_n) |-> !p0_oe);

   a_r8_psen_quiet_data: assert property (@(posedge clk) disable iff (rst)
      (!rd_n || !wr_n) |-> psen_n_o);

   a_r9_wr_data_driven: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> (p0_oe && rd_n && p2_oe));

   a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
      $rose(rd_valid) |-> $past(!psen_n_o || !rd_n));
endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W), .SLOT_CLKS(SLOT_CLKS)) u_chk (
   .clk(clk), .rst(rst), .ale_o(ale_o), .ale_oe(ale_oe),
   .psen_n_o(psen_n_o), .psen_oe(psen_oe), .rd_n(rd_n), .wr_n(wr_n),
   .p0_oe(p0_oe), .p0_do(p0_do), .p2_oe(p2_oe), .rd_valid(rd_valid)
);

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ea_n = 1'b1;
   logic        req_code = 1'b0, req_xrd = 1'b0, req_xwr = 1'b0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_take;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic [7:0]  p0_di = '0;
   logic [7:0]  p0_do, p2_do;
   logic        p0_oe, p2_oe, ale_o, ale_oe, psen_n_o, psen_oe, rd_n, wr_n;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   xbus_seq u_dut (
      .clk(clk), .rst(rst), .ea_n(ea_n), .req_code(req_code), .req_xrd(req_xrd),
      .req_xwr(req_xwr), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_take(req_take), .rd_data(rd_data), .rd_valid(rd_valid), .p0_di(p0_di),
      .p0_do(p0_do), .p0_oe(p0_oe), .p2_do(p2_do), .p2_oe(p2_oe), .ale_o(ale_o),
      .ale_oe(ale_oe), .psen_n_o(psen_n_o), .psen_oe(psen_oe), .rd_n(rd_n), .wr_n(wr_n)
   );

   // type 0 code, 1 read, 2 write | ea_n | address | data
   localparam logic [31:0] VEC [0:8] = '{
      32'h014000A5, 32'h013FFF11, 32'h0001235A, 32'h118001C3, 32'h21FFFF3C,
      32'h1100007E, 32'h003FFF96, 32'h21123400, 32'h01FFFF81
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] pins();
      return {ale_oe, psen_oe, ale_o, psen_n_o, rd_n, wr_n, p0_oe, p2_oe,
              p0_oe ? p0_do : 8'h00, p2_oe ? p2_do : 8'h00};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
         finish_run();
      end
   end

   task automatic run_access(input logic [31:0] v);
      logic [1:0]  t    = v[29:28];
      logic        ea   = v[24];
      logic [15:0] a    = v[23:8];
      logic [7:0]  d    = v[7:0];
      logic        ext  = (t != 0) || !ea || (a >= 16'h4000);
      int          n    = (t == 0) ? 6 : 12;
      string       tag;
      if (t == 0) tag = !ext ? "R6 internal fetch" : (!ea ? "R7 forced fetch" : "R5 code fetch");
      else        tag = (t == 1) ? "R8 data read" : "R9 data write";
      @(negedge clk);
      ea_n = ea; req_addr = a; req_wdata = d; p0_di = d;
      req_code = (t == 0); req_xrd = (t == 1); req_xwr = (t == 2);
      while (!req_take) @(negedge clk);
      @(negedge clk);
      req_code = 0; req_xrd = 0; req_xwr = 0;
      for (int j = 0; j < n; j++) begin
         int   p     = j % 6;
         logic first = (j < 6);
         logic e_ale = first && (p < 2);
         logic e_psen = 1, e_rd = 1, e_wr = 1, e_p0oe = 0, e_p2oe = 0;
         logic [7:0] e_p0 = 8'h00;
         if (t == 0 && ext) begin
            e_p2oe = 1; e_p0oe = (p <= 2); e_psen = !(p >= 3); e_p0 = a[7:0];
         end else if (t == 1) begin
            e_p2oe = 1; e_p0oe = first && (p <= 2); e_p0 = a[7:0];
            e_rd = !((first && p >= 4) || !first);
         end else if (t == 2) begin
            e_p2oe = 1; e_p0oe = 1;
            e_p0 = (first && p <= 2) ? a[7:0] : d;
            e_wr = !((first && p >= 4) || !first);
         end
         check($sformatf("%s R3 R4 cycle %0d", tag, j), {8'h0, pins()},
               {8'h0, 1'b1, 1'b1, e_ale, e_psen, e_rd, e_wr, e_p0oe, e_p2oe,
                e_p0oe ? e_p0 : 8'h00, e_p2oe ? a[15:8] : 8'h00});
         if (j == 5 || j == 11)
            check($sformatf("%s R10 no take without request", tag), {31'b0, req_take}, 32'h0);
         @(negedge clk);
      end
      if (t == 2 || !ext) check({tag, " no rd_valid"}, {31'b0, rd_valid}, 32'h0);
      else check({tag, " rd_valid/rd_data"}, {23'b0, rd_valid, rd_data}, {23'b0, 1'b1, d});
   endtask

   initial begin
      int rises, highs;
      logic prev;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 reset pads", {8'h0, pins()} & 32'h00FF_0000, {8'h0, 8'b0011_1100, 16'h0});
      @(negedge clk);
      rst = 1'b0;
      // R2 continuous ALE in idle slots: first negedge after release is phase 1
      rises = 0; highs = 0; prev = 1'b1;
      for (int k = 0; k < 36; k++) begin
         @(negedge clk);
         if (ale_o) highs++;
         if (ale_o && !prev) rises++;
         prev = ale_o;
      end
      check("R2 ALE rises in 36 clocks", rises, 6);
      check("R2 ALE high clocks in 36", highs, 12);
      check("R2 strobe pads driven", {30'b0, ale_oe, psen_oe}, 32'h3);

      // table walk
      for (int i = 0; i < 9; i++) run_access(VEC[i]);

      // R10 priority and no sampling mid-access
      @(negedge clk);
      ea_n = 1; req_addr = 16'h9000; p0_di = 8'h44;
      req_code = 1; req_xrd = 1; req_xwr = 1;
      while (!req_take) @(negedge clk);
      @(negedge clk);
      req_xrd = 0; req_xwr = 0;
      for (int j = 0; j < 12; j++) begin
         if (j == 4) check("R10 read wins over code and write",
                           {29'b0, psen_n_o, rd_n, wr_n}, 32'h5);
         if (j == 5) check("R10 no take at end of first data slot", {31'b0, req_take}, 32'h0);
         if (j == 11) check("R10 pending code taken after data", {31'b0, req_take}, 32'h1);
         @(negedge clk);
      end
      req_code = 0;
      repeat (8) @(negedge clk);

      // R1 reset in the middle of a write
      req_addr = 16'h2222; req_wdata = 8'h99; req_xwr = 1;
      while (!req_take) @(negedge clk);
      @(negedge clk);
      req_xwr = 0;
      repeat (7) @(negedge clk);
      check("R9 write strobe active before reset", {31'b0, wr_n}, 32'h0);
      rst = 1'b1;
      #1;
      check("R1 async reset mid write", {8'h0, pins()} & 32'h00FF_0000, {8'h0, 8'b0011_1100, 16'h0});
      @(negedge clk);
      rst = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule